// File: doc/BRIEF.md
# Ternary Weight Row Reader for Differential Resistive Synapses

This block sequences the read of one row of a differential resistive-memory array whose columns each end in a precharge sense amplifier. On a read request it selects the addressed word line and holds the sense-enable low for a fixed precharge phase. It then raises sense-enable for an evaluation window whose length in clock cycles comes from an input. At the last cycle of that window it samples every column's complementary amplifier outputs and decodes each one into a ternary weight.

A column whose two outputs have split apart decodes as +1 or -1, depending on which side went high. The cell pair holds +1 as low/high resistance and -1 as high/low. A pair left in high/high resistance resolves slowly, so its outputs are normally still equal when the window closes, and the block reads that as weight 0 rather than as a fault. The low/low combination is never programmed. The window length therefore sets where a slow pair stops counting as signed. The evaluation count is 7 cycles for a 70 ns window at 100 MHz.

The decoded row comes out as a packed vector of 2-bit two's-complement codes with a one-cycle valid pulse. The vector holds its value until the next read completes.

Top module: `tern_row_reader`

## Requirements
- R1: After synchronous reset, sense-enable is low, every word line is low, valid is low and every weight code is 00.
- R2: A request seen at a clock edge while idle starts a read: for the next PRE_CYCLES cycles (default 2) the addressed word line is high and sense-enable is low.
- R3: After the precharge, sense-enable stays high for exactly the evaluation count cycles; a count of 0 is treated as 1.
- R4: During a read exactly one word line is high, the one whose index equals the captured row address; all word lines are low when the read is not active, including the cycle in which valid is high.
- R5: Column c is reported in bits [2c+1:2c] of the weight vector: 01 (+1) when Q and Qb differ with Q high, 11 (-1) when they differ with Q low, 00 (0) when they are equal.
- R6: The decoded values are those that Q and Qb carry in the last cycle of sense-enable high, so a column that resolves later than the window reads 0, and a longer window lets it read signed.
- R7: Valid is high for exactly one cycle, the cycle right after the last sense-enable cycle, and the weight vector keeps its value until the next read completes.
- R8: A request that arrives while a read is in progress is ignored: the row, the window length and the number of valid pulses of the current read are unchanged, and no second read follows.
- R9: The row address and evaluation count are captured with the accepted request; later changes to those inputs during the read have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, taken only when idle |
| rd_row | input | 5 | Row address of the read |
| eval_len | input | 8 | Evaluation window length in cycles (0 acts as 1) |
| wl | output | 32 | One-hot word-line selects |
| sen | output | 1 | Sense-enable: low precharges, high evaluates |
| sa_q | input | 32 | Per-column sense amplifier Q output |
| sa_qb | input | 32 | Per-column sense amplifier Qb output |
| wt | output | 64 | Ternary weights, 2 bits per column |
| wt_valid | output | 1 | One-cycle pulse when the weight vector is new |

## Verification
Every cycle, the assertions check several properties. Sense-enable never rises without a precharge cycle before it, and it is only high under an active word line. Valid is a single-cycle pulse with all word lines down. The weight vector moves only after a sampling cycle, and each column's code follows the Q/Qb pair seen at that cycle. A request during a read leaves the captured row alone. Only the bench scenarios can show the window position. A behavioural amplifier model resolves signed cells quickly and high/high cells slowly. Reading the same rows with windows of 0, 1, 2, 4, 7 and 12 cycles shows which columns fall on each side of the cutoff, and shows that a request mid-read never starts a second read.

// File: rtl/tern_rd_pkg.sv
package tern_rd_pkg;

    // two's-complement ternary weight codes
    typedef logic [1:0] tw_t;
    localparam tw_t TW_ZERO = 2'b00;
    localparam tw_t TW_POS  = 2'b01;
    localparam tw_t TW_NEG  = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EVAL = 2'd2
    } phase_t;

    // resolved pair -> signed weight, unresolved pair -> zero
    function automatic tw_t sa_to_weight(input logic q, input logic qb);
        if (q ^ qb) return q ? TW_POS : TW_NEG;
        return TW_ZERO;
    endfunction

endpackage

// File: rtl/phase_ctrl.sv
module phase_ctrl
    import tern_rd_pkg::*;
#(
    parameter int ROW_AW     = 5,
    parameter int CNT_W      = 8,
    parameter int PRE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ROW_AW-1:0] row_in,
    input  logic [CNT_W-1:0]  win_in,
    output logic              busy,
    output logic              sen,
    output logic              sample,
    output logic [ROW_AW-1:0] row_q
);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYCLES - 1);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            win_q <= CNT_W'(1);
            row_q <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (req) begin
                    ph    <= PH_PRE;
                    cnt   <= PRE_LAST;
                    row_q <= row_in;
                    win_q <= (win_in == '0) ? CNT_W'(1) : win_in;
                end
                PH_PRE: begin
                    if (cnt == '0) begin
                        ph  <= PH_EVAL;
                        cnt <= win_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_EVAL: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - CNT_W'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (ph != PH_IDLE);
    assign sen    = (ph == PH_EVAL);
    assign sample = (ph == PH_EVAL) && (cnt == '0);

    // R2: evaluation is always preceded by a precharge cycle of the same read
    a_r2_pre_before_eval: assert property (@(posedge clk) disable iff (rst)
        $rose(sen) |-> ($past(busy) && !$past(sen)));

    // R8/R9: a request while busy does not disturb the captured row
    a_r8_busy_keeps_row: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> $stable(row_q));

endmodule

// File: rtl/wl_drv.sv
module wl_drv #(
    parameter int NROW   = 32,
    parameter int ROW_AW = 5
) (
    input  logic              en,
    input  logic [ROW_AW-1:0] row,
    output logic [NROW-1:0]   wl
);
    for (genvar i = 0; i < NROW; i++) begin : g_wl
        assign wl[i] = en && (row == ROW_AW'(i));
    end
endmodule

// File: rtl/col_decode.sv
module col_decode
    import tern_rd_pkg::*;
#(
    parameter int NCOL = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [NCOL-1:0]   q,
    input  logic [NCOL-1:0]   qb,
    output logic [2*NCOL-1:0] wt,
    output logic              vld
);
    always_ff @(posedge clk) begin
        if (rst) vld <= 1'b0;
        else     vld <= sample;
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst)         wt[2*c +: 2] <= TW_ZERO;
            else if (sample) wt[2*c +: 2] <= sa_to_weight(q[c], qb[c]);
        end

        // R5: split pair gives the sign of Q
        a_r5_signed: assert property (@(posedge clk) disable iff (rst)
            (sample && (q[c] != qb[c])) |=>
                (wt[2*c +: 2] == ($past(q[c]) ? TW_POS : TW_NEG)));

        // R5/R6: equal pair at the sampling cycle gives zero
        a_r5_zero: assert property (@(posedge clk) disable iff (rst)
            (sample && (q[c] == qb[c])) |=> (wt[2*c +: 2] == TW_ZERO));
    end

    // R7: valid is a single-cycle pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R7: weights move only after a sampling cycle
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(wt));

endmodule

// File: rtl/tern_row_reader.sv
module tern_row_reader
    import tern_rd_pkg::*;
#(
    parameter int NCOL       = 32,
    parameter int NROW       = 32,
    parameter int CNT_W      = 8,
    parameter int PRE_CYCLES = 2,
    localparam int ROW_AW    = $clog2(NROW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ROW_AW-1:0] rd_row,
    input  logic [CNT_W-1:0]  eval_len,
    output logic [NROW-1:0]   wl,
    output logic              sen,
    input  logic [NCOL-1:0]   sa_q,
    input  logic [NCOL-1:0]   sa_qb,
    output logic [2*NCOL-1:0] wt,
    output logic              wt_valid
);
    logic              busy;
    logic              sample;
    logic [ROW_AW-1:0] row_q;

    phase_ctrl #(
        .ROW_AW    (ROW_AW),
        .CNT_W     (CNT_W),
        .PRE_CYCLES(PRE_CYCLES)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_req),
        .row_in(rd_row),
        .win_in(eval_len),
        .busy  (busy),
        .sen   (sen),
        .sample(sample),
        .row_q (row_q)
    );

    wl_drv #(
        .NROW  (NROW),
        .ROW_AW(ROW_AW)
    ) u_wl (
        .en (busy),
        .row(row_q),
        .wl (wl)
    );

    col_decode #(
        .NCOL(NCOL)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .sample(sample),
        .q     (sa_q),
        .qb    (sa_qb),
        .wt    (wt),
        .vld   (wt_valid)
    );

    // R3: evaluation only under a selected word line
    a_r3_sen_under_wl: assert property (@(posedge clk) disable iff (rst)
        sen |-> ($countones(wl) == 1));

    // R4: word line dropped and sensing off when the result is presented
    a_r4_wl_off_at_valid: assert property (@(posedge clk) disable iff (rst)
        wt_valid |-> ((wl == '0) && !sen));

    // R4: never more than one word line
    a_r4_wl_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wl));

endmodule

// File: tb/tb_tern_row_reader.sv
`timescale 1ns/1ps
module tb_tern_row_reader;
    localparam int NCOL = 32;
    localparam int NROW = 32;
    localparam int PRE  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_req = 1'b0;
    logic [4:0]        rd_row = '0;
    logic [7:0]        eval_len = '0;
    logic [NROW-1:0]   wl;
    logic              sen;
    logic [NCOL-1:0]   sa_q;
    logic [NCOL-1:0]   sa_qb;
    logic [2*NCOL-1:0] wt;
    logic              wt_valid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tern_row_reader dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_row(rd_row),
        .eval_len(eval_len), .wl(wl), .sen(sen), .sa_q(sa_q),
        .sa_qb(sa_qb), .wt(wt), .wt_valid(wt_valid)
    );

    // ---- behavioural cell and sense amplifier model ----
    // kind 0: low/high pair (+1), kind 1: high/low (-1), kind 2: high/high (slow)
    function automatic int kind(input int r, input int c);
        return (r * 7 + c * 3) % 3;
    endfunction
    function automatic int settle(input int r, input int c);
        return (kind(r, c) == 2) ? 8 + (c % 4) : (c % 4);
    endfunction
    function automatic bit side(input int r, input int c);
        if (kind(r, c) == 0) return 1'b1;
        if (kind(r, c) == 1) return 1'b0;
        return bit'((r + c) % 2);
    endfunction

    int scnt = 0;
    always @(posedge clk) begin
        if (!sen) scnt <= 0;
        else      scnt <= scnt + 1;
    end

    always_comb begin
        int r;
        r = -1;
        for (int i = 0; i < NROW; i++) if (wl[i]) r = i;
        for (int c = 0; c < NCOL; c++) begin
            if (sen && r >= 0 && scnt >= settle(r, c)) begin
                sa_q[c]  = side(r, c);
                sa_qb[c] = ~side(r, c);
            end else begin
                sa_q[c]  = 1'b1;
                sa_qb[c] = 1'b1;
            end
        end
    end

    // expected decoded row: resolved if settle < window length
    function automatic logic [2*NCOL-1:0] exp_vec(input int r, input int n);
        logic [2*NCOL-1:0] v;
        int ne;
        ne = (n == 0) ? 1 : n;
        for (int c = 0; c < NCOL; c++) begin
            if (settle(r, c) < ne) v[2*c +: 2] = side(r, c) ? 2'b01 : 2'b11;
            else                   v[2*c +: 2] = 2'b00;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // runs one read; optionally pokes a second request at loop step poke
    task automatic do_read(input int r, input int n, input int poke,
                           output int pre_n, output int sen_n,
                           output bit wl_ok, output bit vseen);
        @(negedge clk);
        rd_req = 1'b1; rd_row = 5'(r); eval_len = 8'(n);
        @(negedge clk);
        rd_req = 1'b0;
        pre_n = 0; sen_n = 0; wl_ok = 1'b1; vseen = 1'b0;
        for (int k = 0; k < 300 && !vseen; k++) begin
            if (k == poke) begin
                rd_req = 1'b1; rd_row = 5'(r ^ 5'h0a); eval_len = 8'd1;
            end else begin
                rd_req = 1'b0;
            end
            if (wt_valid) begin
                vseen = 1'b1;
                if (wl != '0 || sen) wl_ok = 1'b0;
            end else begin
                if (wl != (NROW'(1) << r)) wl_ok = 1'b0;
                if (sen) sen_n++; else pre_n++;
                @(negedge clk);
            end
        end
        rd_req = 1'b0;
        if (!vseen) begin
            fails++;
            $display("FAIL R7 actual=no_valid expected=valid_pulse (watchdog)");
        end
    endtask

    localparam int NV = 6;
    localparam logic [12:0] VEC [NV] = '{
        {5'd3,  8'd7}, {5'd0,  8'd2}, {5'd31, 8'd12},
        {5'd17, 8'd1}, {5'd9,  8'd0}, {5'd22, 8'd4}
    };

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int pre_n, sen_n;
        bit wl_ok, vseen;
        logic [2*NCOL-1:0] e, held;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sen == 1'b0, "R1 sen", $sformatf("%b", sen), "0");
        chk(wl == '0, "R1 wl", $sformatf("%h", wl), "0");
        chk(wt_valid == 1'b0, "R1 valid", $sformatf("%b", wt_valid), "0");
        chk(wt == '0, "R1 wt", $sformatf("%h", wt), "0");
        rst = 1'b0;

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            int r, n, ne;
            r = int'(VEC[i][12:8]);
            n = int'(VEC[i][7:0]);
            ne = (n == 0) ? 1 : n;
            do_read(r, n, -1, pre_n, sen_n, wl_ok, vseen);
            e = exp_vec(r, n);
            chk(pre_n == PRE, "R2 precharge cycles", $sformatf("%0d", pre_n), $sformatf("%0d", PRE));
            chk(sen_n == ne, "R3 eval cycles", $sformatf("%0d", sen_n), $sformatf("%0d", ne));
            chk(wl_ok, "R4 word line", $sformatf("%b", wl_ok), "1");
            chk(wt == e, "R5 R6 weights", $sformatf("%h", wt), $sformatf("%h", e));
            @(negedge clk);
            chk(!wt_valid, "R7 valid single cycle", $sformatf("%b", wt_valid), "0");
        end

        // R7: hold after valid
        held = wt;
        repeat (5) @(negedge clk);
        chk(wt == held && !wt_valid, "R7 hold", $sformatf("%h", wt), $sformatf("%h", held));

        // R8 R9: request with other row and window while busy
        do_read(5, 6, 3, pre_n, sen_n, wl_ok, vseen);
        e = exp_vec(5, 6);
        chk(sen_n == 6, "R9 window kept", $sformatf("%0d", sen_n), "6");
        chk(wl_ok, "R8 row kept", $sformatf("%b", wl_ok), "1");
        chk(wt == e, "R8 weights of first read", $sformatf("%h", wt), $sformatf("%h", e));
        begin
            bit quiet;
            quiet = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (wl != '0 || sen || wt_valid) quiet = 1'b0;
            end
            chk(quiet, "R8 no second read", $sformatf("%b", quiet), "1");
        end
        chk(wt == e, "R7 R8 weights unchanged", $sformatf("%h", wt), $sformatf("%h", e));

        // R6: same row, short and long windows give different zero columns
        do_read(31, 3, -1, pre_n, sen_n, wl_ok, vseen);
        e = exp_vec(31, 3);
        chk(wt == e, "R6 short window", $sformatf("%h", wt), $sformatf("%h", e));

        // R1: reset mid-read clears everything
        @(negedge clk);
        rd_req = 1'b1; rd_row = 5'd4; eval_len = 8'd9;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(wl == '0 && !sen && !wt_valid && wt == '0, "R1 reset mid-read",
            $sformatf("%h/%b/%h", wl, sen, wt), "0/0/0");
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule